// File: doc/BRIEF.md
# OTG Status Edge Interrupt Latch

This block watches five slowly changing status signals from a USB On-The-Go front end: host disconnect, VBUS valid, session valid, session end and ID ground. Each signal is brought into the clock domain through a two-stage synchronizer. Two software-visible enable masks, one for rising transitions and one for falling transitions, decide which transitions count as events for each source. A counted event sets a sticky per-source latch bit and raises a one-cycle request that asks the link interface to send a status report.

A small register port gives access to four views: the rising-edge mask, the falling-edge mask, the live synchronized levels, and the latch bits. The masks take a load, set-bits or clear-bits operation. Reading the latch view returns its contents and empties it in the same clock edge. An event that arrives on that same edge survives the clear. The interrupt output is high while any latch bit is set.

Top module: `otg_evt_latch`

## Requirements
- R1: After synchronous reset both masks, all latch bits, the read data, the interrupt output and the report request are zero.
- R2: A level view read returns the source levels after the two-stage synchronizer. An input change made just before clock edge E1 is visible to a read sampled at edge E3 and not to one sampled at edge E2.
- R3: A rising transition on a source whose rising-mask bit is 1 sets its latch bit. With the input changed before edge E1, the latch and the interrupt output are set after edge E3.
- R4: A falling transition on a source whose falling-mask bit is 1 sets its latch bit with the same three-edge latency.
- R5: A transition whose direction is not enabled for that source leaves its latch bit clear and produces no report request.
- R6: A mask write uses op code 0 to load the data, 1 to set the bits where the data is 1, 2 to clear the bits where the data is 1, and 3 to leave the mask unchanged. Select code 0 picks the rising mask and 1 the falling mask.
- R7: A read with select code 3 returns the latch bits on the next cycle's read data and clears them at the same edge. Select code 2 returns the levels.
- R8: An event that lands on the same edge as a clearing latch read keeps its latch bit set after that edge.
- R9: The interrupt output is high exactly while any latch bit is set. It falls in the cycle after a clearing read when no new event arrives.
- R10: The report request is a one-cycle pulse. It is high in the same cycle in which a counted event sets its latch bit.
- R11: The bit positions in the masks, levels and latches are: bit 0 host disconnect, bit 1 VBUS valid, bit 2 session valid, bit 3 session end, bit 4 ID ground.
- R12: A write with select code 2 or 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | SRC_N | Raw asynchronous status levels |
| reg_sel_i | input | 2 | View select: 0 rising mask, 1 falling mask, 2 levels, 3 latches |
| reg_op_i | input | 2 | Write operation: 0 load, 1 set bits, 2 clear bits, 3 none |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe; a read of the latches clears them |
| reg_wdata_i | input | SRC_N | Write data |
| reg_rdata_o | output | SRC_N | Registered read data, held between reads |
| irq_o | output | 1 | High while any latch bit is set |
| rpt_req_o | output | 1 | One-cycle request for a status report |

## Verification
On every cycle the assertions check these rules: a newly set latch bit always had a mask bit enabled, an event is never lost to a clearing read, a clearing read with no event empties the latches, a set-bits operation leaves the addressed bits at 1, and the interrupt only rises together with a report request. The exact three-edge latency, the two-edge level visibility, the priority between a read and a coincident event, and the bit positions can only be shown by the bench's directed scenarios. A cycle-accurate bench model then checks long random mixes of source toggles, mask operations and reads against the design.

// File: rtl/otg_evt_pkg.sv
// Package: shared constants and encodings for the OTG status edge latch.
// Assumes: the register port uses a two-bit select and a two-bit op code.
package otg_evt_pkg;
    localparam int SRC_N = 5;

    typedef enum logic [1:0] {
        SEL_RISE  = 2'd0,
        SEL_FALL  = 2'd1,
        SEL_LEVEL = 2'd2,
        SEL_LATCH = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_NONE = 2'd3
    } reg_op_e;
endpackage

// File: rtl/otg_evt_sync.sv
// Module: multi-stage synchronizer for a vector of slow, independent levels.
// Assumes: each bit changes rarely, so bits need no mutual coherence.
module otg_evt_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o
);
    logic [W-1:0] stg_q [STAGES];

    // Shift raw levels through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            stg_q[0] <= raw_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign lvl_o = stg_q[STAGES-1];
endmodule

// File: rtl/otg_evt_edge.sv
// Module: per-source transition detector gated by rising and falling masks.
// Assumes: lvl_i is already synchronous; evt_o is combinational from registers.
module otg_evt_edge #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] en_rise_i,
    input  logic [W-1:0] en_fall_i,
    output logic [W-1:0] evt_o
);
    logic [W-1:0] prev_q;

    // Hold the previous synchronized level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_src
        assign evt_o[i] = (en_rise_i[i] &  lvl_i[i] & ~prev_q[i])
                        | (en_fall_i[i] & ~lvl_i[i] &  prev_q[i]);
    end

    // An event requires the level to have just moved.
    p_evt_moved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o & ~(lvl_i ^ prev_q)) == '0);
endmodule

// File: rtl/otg_evt_regs.sv
// Module: edge masks, sticky latches, read port with clear-on-read, report pulse.
// Assumes: a latch read and a new event on the same edge keep the event.
module otg_evt_regs
    import otg_evt_pkg::*;
#(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] evt_i,
    input  logic [1:0]   sel_i,
    input  logic [1:0]   op_i,
    input  logic         wr_i,
    input  logic         rd_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_rise_o,
    output logic [W-1:0] en_fall_o,
    output logic [W-1:0] rdata_o,
    output logic         irq_o,
    output logic         rpt_o
);
    reg_sel_e     sel;
    reg_op_e      op;
    logic [W-1:0] en_r_q, en_f_q, latch_q, rdata_q;
    logic         rpt_q;
    logic         rd_clr;

    assign sel    = reg_sel_e'(sel_i);
    assign op     = reg_op_e'(op_i);
    assign rd_clr = rd_i && (sel == SEL_LATCH);

    function automatic logic [W-1:0] f_apply(input logic [W-1:0] cur,
                                             input reg_op_e o,
                                             input logic [W-1:0] d);
        case (o)
            OP_LOAD: return d;
            OP_SET:  return cur | d;
            OP_CLR:  return cur & ~d;
            default: return cur;
        endcase
    endfunction

    // Apply write operations to the two edge masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_r_q <= '0;
            en_f_q <= '0;
        end else if (wr_i) begin
            case (sel)
                SEL_RISE: en_r_q <= f_apply(en_r_q, op, wdata_i);
                SEL_FALL: en_f_q <= f_apply(en_f_q, op, wdata_i);
                default:  ;
            endcase
        end
    end

    // Sticky latches: cleared by a latch read, new events always win.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= (rd_clr ? '0 : latch_q) | evt_i;
    end

    // Capture the selected view on a read; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (rd_i) begin
            case (sel)
                SEL_RISE:  rdata_q <= en_r_q;
                SEL_FALL:  rdata_q <= en_f_q;
                SEL_LEVEL: rdata_q <= lvl_i;
                default:   rdata_q <= latch_q;
            endcase
        end
    end

    // One-cycle report request whenever any counted event occurs.
    always_ff @(posedge clk) begin
        if (!rst_n) rpt_q <= 1'b0;
        else        rpt_q <= |evt_i;
    end

    assign en_rise_o = en_r_q;
    assign en_fall_o = en_f_q;
    assign rdata_o   = rdata_q;
    assign irq_o     = |latch_q;
    assign rpt_o     = rpt_q;

    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q & ~$past(latch_q) & ~($past(en_r_q) | $past(en_f_q))) == '0);

    p_keep_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((latch_q & $past(evt_i)) == $past(evt_i)));

    p_clear_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && evt_i == '0) |=> (latch_q == '0));

    p_set_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel == SEL_RISE && op == OP_SET)
        |=> ((en_r_q & $past(wdata_i)) == $past(wdata_i)));
endmodule

// File: rtl/otg_evt_latch.sv
// Module: top of the OTG status edge interrupt latch.
// Assumes: src_i bits are asynchronous levels; register port is single-cycle.
module otg_evt_latch
    import otg_evt_pkg::*;
#(
    parameter int SRC_W     = SRC_N,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic [1:0]       reg_sel_i,
    input  logic [1:0]       reg_op_i,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [SRC_W-1:0] reg_wdata_i,
    output logic [SRC_W-1:0] reg_rdata_o,
    output logic             irq_o,
    output logic             rpt_req_o
);
    logic [SRC_W-1:0] lvl, evt, en_rise, en_fall;

    otg_evt_sync #(.W(SRC_W), .STAGES(SYNC_DEPTH)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (src_i),
        .lvl_o (lvl)
    );

    otg_evt_edge #(.W(SRC_W)) i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (lvl),
        .en_rise_i (en_rise),
        .en_fall_i (en_fall),
        .evt_o     (evt)
    );

    otg_evt_regs #(.W(SRC_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (lvl),
        .evt_i     (evt),
        .sel_i     (reg_sel_i),
        .op_i      (reg_op_i),
        .wr_i      (reg_wr_i),
        .rd_i      (reg_rd_i),
        .wdata_i   (reg_wdata_i),
        .en_rise_o (en_rise),
        .en_fall_o (en_fall),
        .rdata_o   (reg_rdata_o),
        .irq_o     (irq_o),
        .rpt_o     (rpt_req_o)
    );

    // The interrupt can only rise together with a report request.
    p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> rpt_req_o);

    // A report request always coincides with a pending latch.
    p_rpt_with_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_req_o |-> irq_o);
endmodule

// File: tb/test_otg_evt_latch.sv
// Bench: directed corner cases then seeded random traffic against a bench model.
module test_otg_evt_latch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src = '0;
    logic [1:0] sel = '0;
    logic [1:0] op = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [4:0] wd = '0;
    logic [4:0] rdata;
    logic       irq, rpt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    otg_evt_latch i_otg_evt_latch (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_sel_i(sel), .reg_op_i(op),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wd), .reg_rdata_o(rdata),
        .irq_o(irq), .rpt_req_o(rpt)
    );

    // Bench model built from the requirements.
    logic [4:0] m_s1, m_s2, m_prev, m_er, m_ef, m_lat, m_rd, m_ev;
    logic       m_rpt;

    function automatic logic [4:0] f_op(input logic [4:0] c, input logic [1:0] o,
                                        input logic [4:0] d);
        case (o)
            2'd0: return d;
            2'd1: return c | d;
            2'd2: return c & ~d;
            default: return c;
        endcase
    endfunction

    function automatic logic [4:0] f_evt(input logic [4:0] now, input logic [4:0] old,
                                         input logic [4:0] er, input logic [4:0] ef);
        return (er & now & ~old) | (ef & ~now & old);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_er <= '0; m_ef <= '0;
            m_lat <= '0; m_rd <= '0; m_rpt <= 1'b0;
        end else begin
            m_ev = f_evt(m_s2, m_prev, m_er, m_ef);
            m_s1 <= src; m_s2 <= m_s1; m_prev <= m_s2;
            if (rd) begin
                case (sel)
                    2'd0: m_rd <= m_er;
                    2'd1: m_rd <= m_ef;
                    2'd2: m_rd <= m_s2;
                    default: m_rd <= m_lat;
                endcase
            end
            m_lat <= ((rd && sel == 2'd3) ? 5'd0 : m_lat) | m_ev;
            m_rpt <= |m_ev;
            if (wr && sel == 2'd0) m_er <= f_op(m_er, op, wd);
            if (wr && sel == 2'd1) m_ef <= f_op(m_ef, op, wd);
        end
    end

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic nedge(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_wr(input logic [1:0] s, input logic [1:0] o, input logic [4:0] d);
        sel = s; op = o; wd = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] s, output logic [4:0] v);
        sel = s; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [4:0] v;
        nedge(3);
        rst_n = 1'b1;
        nedge(1);
        // R1 reset state
        chk("R1 irq", {4'd0, irq}, 5'd0);
        chk("R1 rpt", {4'd0, rpt}, 5'd0);
        chk("R1 rdata", rdata, 5'd0);
        do_rd(2'd0, v); chk("R1 rise mask", v, 5'd0);
        do_rd(2'd1, v); chk("R1 fall mask", v, 5'd0);
        do_rd(2'd3, v); chk("R1 latches", v, 5'd0);

        // R6 mask operations
        do_wr(2'd0, 2'd0, 5'h05); do_rd(2'd0, v); chk("R6 load", v, 5'h05);
        do_wr(2'd0, 2'd1, 5'h02); do_rd(2'd0, v); chk("R6 set", v, 5'h07);
        do_wr(2'd0, 2'd2, 5'h04); do_rd(2'd0, v); chk("R6 clear", v, 5'h03);
        do_wr(2'd0, 2'd3, 5'h1f); do_rd(2'd0, v); chk("R6 none", v, 5'h03);
        do_wr(2'd1, 2'd0, 5'h18); do_rd(2'd1, v); chk("R6 fall load", v, 5'h18);

        // R12 writes to level and latch views change nothing
        do_wr(2'd2, 2'd0, 5'h1f);
        do_wr(2'd3, 2'd1, 5'h1f);
        chk("R12 irq", {4'd0, irq}, 5'd0);
        do_rd(2'd3, v); chk("R12 latches", v, 5'd0);
        do_rd(2'd0, v); chk("R12 rise mask", v, 5'h03);

        // R3 R10 R11 rising host disconnect (bit 0) latency
        src[0] = 1'b1;
        nedge(2);
        chk("R3 no latch yet", {4'd0, irq}, 5'd0);
        chk("R10 no pulse yet", {4'd0, rpt}, 5'd0);
        nedge(1);
        chk("R3 irq set", {4'd0, irq}, 5'd1);
        chk("R10 pulse", {4'd0, rpt}, 5'd1);
        nedge(1);
        chk("R10 pulse width", {4'd0, rpt}, 5'd0);

        // R2 level visibility after two stages; R5 session valid rise not enabled
        src[2] = 1'b1;
        nedge(1);
        do_rd(2'd2, v); chk("R2 level at E2", v, 5'h01);
        do_rd(2'd2, v); chk("R2 level at E3 R11", v, 5'h05);
        nedge(3);
        chk("R5 no pulse", {4'd0, rpt}, 5'd0);
        // R7 R9 clear-on-read
        do_rd(2'd3, v); chk("R7 latch read R11 R5", v, 5'h01);
        chk("R9 irq drops", {4'd0, irq}, 5'd0);
        do_rd(2'd3, v); chk("R7 latches empty", v, 5'h00);

        // R4 falling session end (bit 3)
        src[3] = 1'b1;
        nedge(4);
        chk("R4 rise ignored", {4'd0, irq}, 5'd0);
        src[3] = 1'b0;
        nedge(2);
        chk("R4 not yet", {4'd0, irq}, 5'd0);
        nedge(1);
        chk("R4 irq set", {4'd0, irq}, 5'd1);
        do_rd(2'd3, v); chk("R4 latch R11", v, 5'h08);

        // R8 event coinciding with a clearing read
        src[1] = 1'b1; src[4] = 1'b1;
        nedge(4);
        src[4] = 1'b0;
        nedge(2);
        do_rd(2'd3, v); chk("R8 read value", v, 5'h02);
        chk("R8 irq kept", {4'd0, irq}, 5'd1);
        do_rd(2'd3, v); chk("R8 survivor R11", v, 5'h10);
        chk("R9 irq cleared", {4'd0, irq}, 5'd0);

        // Random phase against the bench model
        void'($urandom(32'd1234));
        for (int c = 0; c < 4000; c++) begin
            chk("R9 random irq", {4'd0, irq}, {4'd0, |m_lat});
            chk("R10 random rpt", {4'd0, rpt}, {4'd0, m_rpt});
            chk("R7 random rdata", rdata, m_rd);
            for (int b = 0; b < 5; b++)
                if ($urandom_range(7) == 0) src[b] = ~src[b];
            rd  = ($urandom_range(2) == 0);
            wr  = ($urandom_range(3) == 0);
            sel = 2'($urandom_range(3));
            op  = 2'($urandom_range(3));
            wd  = 5'($urandom);
            @(negedge clk);
        end
        rd = 1'b0; wr = 1'b0;
        finish_run();
    end
endmodule